// File: doc/BRIEF.md
# Conversion Result Register with Valid Flag

This block holds the most recent result delivered by an analog-to-digital conversion sequencer. The sequencer presents a one-cycle strobe together with a 15-bit value and a set of tags: a group number, a channel number, an external multiplexer setting, a request-source identifier and a fast-compare bit. The register keeps the value and its tags in one 32-bit word. A valid flag marks a result that software has not yet consumed.

Two storage policies are available. In the overwrite policy, every strobe replaces the stored word. In the hold-until-read policy, a strobe that arrives while the valid flag is set is dropped, and a lost-result flag records the drop. Each stored result sets an event flag and, when enabled, pulses a service request.

A small bus port has two addresses. Address 0 is the result word: reading it consumes the result, and writing it can clear the valid flag. Address 1 is the event and status word, whose flags are cleared by write-one command bits.

The valid flag is driven by a two-state machine:
- EMPTY moves to FULL on a store.
- FULL stays in FULL on a store.
- FULL moves to EMPTY on a consuming read or a software clear.
- A software clear always leads to EMPTY.

Top module: `result_reg`

## Requirements
- R1: The address-0 word is laid out as follows. Bits 14:0 hold the result, 18:16 the group, 23:20 the channel, 26:25 the multiplexer setting, 28 the source, 29 the compare bit and 31 the valid flag. All other bits read 0. `bus_rdata` shows the word selected by `bus_addr` combinationally.
- R2: After reset, both bus words read 0, and `res_valid` and `srq` are 0.
- R3: A store sets the valid flag. A bus write to address 0 with bit 31 set clears the valid flag and the reduction placeholder bit (status bit 2), even when a store happens in the same cycle. A store sets the placeholder bit.
- R4: With `cfg_hold` = 0, every strobe stores its value and tags, replacing the previous word.
- R5: With `cfg_hold` = 1, a strobe that arrives while the valid flag is set stores nothing, and the word is unchanged.
- R6: The address-1 word has the event flag in bit 0, the lost flag in bit 1 and the placeholder in bit 2. The event flag is set by each store. Writing 1 to address-1 bit 16 clears it, but a store in the same cycle wins. The clear-command bits read 0.
- R7: When `cfg_srq_en` = 1, `srq` is high for exactly the cycle after each store. Otherwise it stays 0.
- R8: A strobe dropped under R5 sets the lost flag. Writing 1 to address-1 bit 17 clears it, but a drop in the same cycle wins.
- R9: A store with `cv_cmp_mode` = 1 updates the compare bit and the tags, sets the valid flag, and leaves the result field unchanged.
- R10: A read with `bus_rd` = 1 at address 0 clears the valid flag at the next edge, unless a store occurs in the same cycle.
- R11: Bus write data bits other than bit 31 at address 0, and bits 16 and 17 at address 1, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_hold | input | 1 | 1 selects hold-until-read, 0 selects overwrite |
| cfg_srq_en | input | 1 | Service request enable |
| cv_strobe | input | 1 | Conversion result available |
| cv_cmp_mode | input | 1 | Result comes from a fast-compare conversion |
| cv_data | input | 15 | Conversion value |
| cv_group | input | 3 | Group number tag |
| cv_chan | input | 4 | Channel number tag |
| cv_xmux | input | 2 | External multiplexer tag |
| cv_src | input | 1 | Request source tag |
| cv_cmp | input | 1 | Compare outcome, 1 = above the compare value |
| bus_addr | input | 1 | 0 = result word, 1 = status word |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| res_valid | output | 1 | Valid flag |
| srq | output | 1 | Service request pulse |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never both high in one cycle. They also assume that the configuration inputs change only between transactions, and that the converter inputs are meaningful only while `cv_strobe` is high. The stimulus drives every input on the falling clock edge. Reads and writes are never raised together. The two configuration bits are swept through all four combinations, and the data and tags are randomised in each phase. Directed sequences cover the same-cycle collisions: a software clear against a store, a read against a store, and a clear command against a new event.

// File: rtl/result_reg_pkg.sv
package result_reg_pkg;
    parameter int RES_W = 15;
    parameter int GRP_W = 3;
    parameter int CH_W  = 4;
    parameter int XM_W  = 2;
    parameter int BUS_W = 32;

    localparam int VALID_BIT   = BUS_W - 1;
    localparam int EVT_CLR_BIT = 16;
    localparam int LOST_CLR_BIT = 17;

    typedef enum logic {VS_EMPTY = 1'b0, VS_FULL = 1'b1} vstate_t;
endpackage

// File: rtl/rr_valid_fsm.sv
module rr_valid_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic store,
    input  logic sw_clr,
    input  logic rd_clr,
    output logic valid
);
    import result_reg_pkg::*;

    vstate_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= VS_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            VS_EMPTY: if (store && !sw_clr) state_nx = VS_FULL;
            VS_FULL:  if (sw_clr || (rd_clr && !store)) state_nx = VS_EMPTY;
            default:  state_nx = VS_EMPTY;
        endcase
    end

    assign valid = (state == VS_FULL);

    AST_SWCLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> !valid); // R3
    AST_STORE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (store && !sw_clr) |=> valid); // R3
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !store) |=> !valid); // R10
endmodule

// File: rtl/rr_store.sv
module rr_store
    import result_reg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             keep_res,
    input  logic [RES_W-1:0] res_in,
    input  logic [GRP_W-1:0] grp_in,
    input  logic [CH_W-1:0]  ch_in,
    input  logic [XM_W-1:0]  xm_in,
    input  logic             src_in,
    input  logic             cmp_in,
    output logic [RES_W-1:0] res_q,
    output logic [GRP_W-1:0] grp_q,
    output logic [CH_W-1:0]  ch_q,
    output logic [XM_W-1:0]  xm_q,
    output logic             src_q,
    output logic             cmp_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            grp_q <= '0;
            ch_q  <= '0;
            xm_q  <= '0;
            src_q <= 1'b0;
            cmp_q <= 1'b0;
        end else if (load) begin
            if (!keep_res) res_q <= res_in;
            grp_q <= grp_in;
            ch_q  <= ch_in;
            xm_q  <= xm_in;
            src_q <= src_in;
            cmp_q <= cmp_in;
        end
    end

    AST_CMP_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (load && keep_res) |=> $stable(res_q)); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(res_q) && $stable(cmp_q))); // R5
endmodule

// File: rtl/rr_events.sv
module rr_events (
    input  logic clk,
    input  logic rst_n,
    input  logic store,
    input  logic dropped,
    input  logic evt_clr,
    input  logic lost_clr,
    input  logic red_clr,
    input  logic srq_en,
    output logic evt,
    output logic lost,
    output logic red,
    output logic srq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt  <= 1'b0;
            lost <= 1'b0;
            red  <= 1'b0;
            srq  <= 1'b0;
        end else begin
            if (store)         evt <= 1'b1;
            else if (evt_clr)  evt <= 1'b0;
            if (dropped)       lost <= 1'b1;
            else if (lost_clr) lost <= 1'b0;
            if (red_clr)       red <= 1'b0;
            else if (store)    red <= 1'b1;
            srq <= store && srq_en;
        end
    end

    AST_EVT_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> evt); // R6
    AST_LOST_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> lost); // R8
    AST_SRQ_ONLY_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        !(store && srq_en) |=> !srq); // R7
endmodule

// File: rtl/result_reg.sv
module result_reg
    import result_reg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_hold,
    input  logic             cfg_srq_en,
    input  logic             cv_strobe,
    input  logic             cv_cmp_mode,
    input  logic [RES_W-1:0] cv_data,
    input  logic [GRP_W-1:0] cv_group,
    input  logic [CH_W-1:0]  cv_chan,
    input  logic [XM_W-1:0]  cv_xmux,
    input  logic             cv_src,
    input  logic             cv_cmp,
    input  logic             bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             res_valid,
    output logic             srq
);
    logic store, dropped, sw_clr, rd_clr, evt_clr, lost_clr;
    logic [RES_W-1:0] res_q;
    logic [GRP_W-1:0] grp_q;
    logic [CH_W-1:0]  ch_q;
    logic [XM_W-1:0]  xm_q;
    logic src_q, cmp_q, evt, lost, red;
    logic wdata_unused;

    assign dropped  = cv_strobe && cfg_hold && res_valid;
    assign store    = cv_strobe && !dropped;
    assign sw_clr   = bus_wr && !bus_addr && bus_wdata[VALID_BIT];
    assign rd_clr   = bus_rd && !bus_addr;
    assign evt_clr  = bus_wr && bus_addr && bus_wdata[EVT_CLR_BIT];
    assign lost_clr = bus_wr && bus_addr && bus_wdata[LOST_CLR_BIT];
    assign wdata_unused = ^{bus_wdata[VALID_BIT-1:LOST_CLR_BIT+1], bus_wdata[EVT_CLR_BIT-1:0]};

    rr_valid_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .store(store), .sw_clr(sw_clr),
        .rd_clr(rd_clr), .valid(res_valid)
    );

    rr_store u_store (
        .clk(clk), .rst_n(rst_n), .load(store), .keep_res(cv_cmp_mode),
        .res_in(cv_data), .grp_in(cv_group), .ch_in(cv_chan), .xm_in(cv_xmux),
        .src_in(cv_src), .cmp_in(cv_cmp),
        .res_q(res_q), .grp_q(grp_q), .ch_q(ch_q), .xm_q(xm_q),
        .src_q(src_q), .cmp_q(cmp_q)
    );

    rr_events u_evt (
        .clk(clk), .rst_n(rst_n), .store(store), .dropped(dropped),
        .evt_clr(evt_clr), .lost_clr(lost_clr), .red_clr(sw_clr),
        .srq_en(cfg_srq_en), .evt(evt), .lost(lost), .red(red), .srq(srq)
    );

    always_comb begin
        if (bus_addr)
            bus_rdata = {{(BUS_W-3){1'b0}}, red, lost, evt};
        else
            bus_rdata = {res_valid, 1'b0, cmp_q, src_q, 1'b0, xm_q, 1'b0,
                         ch_q, 1'b0, grp_q, 1'b0, res_q};
    end

    AST_HOLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_strobe && cfg_hold && res_valid) |=> ($stable(res_q) && $stable(grp_q) && $stable(ch_q))); // R5
    AST_OVERWRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_strobe && !cfg_hold && !cv_cmp_mode) |=> (res_q == $past(cv_data))); // R4
    AST_SRQ_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_strobe && !dropped && cfg_srq_en) |=> srq); // R7
    AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R10
endmodule

// File: tb/result_reg_test.sv
module result_reg_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wm, sen, stb, cm, src, cmp, adr, rd, wr;
    logic [14:0] dat;
    logic [2:0] grp;
    logic [3:0] ch;
    logic [1:0] xm;
    logic [31:0] wd, rdata;
    logic res_valid, srq;
    int nchk = 0, nfail = 0;
    bit done = 0;

    logic [14:0] m_res; logic [2:0] m_grp; logic [3:0] m_ch; logic [1:0] m_xm;
    logic m_src, m_cmp, m_vld, m_evt, m_lost, m_red, m_srq;

    always #4 clk = ~clk;

    result_reg uut (
        .clk(clk), .rst_n(rst_n), .cfg_hold(wm), .cfg_srq_en(sen),
        .cv_strobe(stb), .cv_cmp_mode(cm), .cv_data(dat), .cv_group(grp),
        .cv_chan(ch), .cv_xmux(xm), .cv_src(src), .cv_cmp(cmp),
        .bus_addr(adr), .bus_rd(rd), .bus_wr(wr), .bus_wdata(wd),
        .bus_rdata(rdata), .res_valid(res_valid), .srq(srq)
    );

    function automatic logic [31:0] w0();
        return {m_vld, 1'b0, m_cmp, m_src, 1'b0, m_xm, 1'b0, m_ch, 1'b0, m_grp, 1'b0, m_res};
    endfunction
    function automatic logic [31:0] w1();
        return {29'd0, m_red, m_lost, m_evt};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        stb = 0; cm = 0; dat = 0; grp = 0; ch = 0; xm = 0; src = 0; cmp = 0;
        adr = 0; rd = 0; wr = 0; wd = 0;
    endtask

    task automatic model_reset();
        m_res = 0; m_grp = 0; m_ch = 0; m_xm = 0; m_src = 0; m_cmp = 0;
        m_vld = 0; m_evt = 0; m_lost = 0; m_red = 0; m_srq = 0;
    endtask

    // apply current inputs for one cycle, check read data, then state
    task automatic tick();
        logic st, dr, swc, rdc;
        #1;
        if (adr) chk("R6", rdata, w1()); else chk("R1", rdata, w0());
        dr  = stb && wm && m_vld;
        st  = stb && !dr;
        swc = wr && !adr && wd[31];
        rdc = rd && !adr;
        @(posedge clk);
        m_vld  = swc ? 1'b0 : st ? 1'b1 : rdc ? 1'b0 : m_vld;
        m_red  = swc ? 1'b0 : st ? 1'b1 : m_red;
        m_evt  = st ? 1'b1 : (wr && adr && wd[16]) ? 1'b0 : m_evt;
        m_lost = dr ? 1'b1 : (wr && adr && wd[17]) ? 1'b0 : m_lost;
        m_srq  = st && sen;
        if (st) begin
            if (!cm) m_res = dat;
            m_grp = grp; m_ch = ch; m_xm = xm; m_src = src; m_cmp = cmp;
        end
        @(negedge clk);
        chk("R3", {31'd0, res_valid}, {31'd0, m_vld});
        chk("R7", {31'd0, srq}, {31'd0, m_srq});
        idle();
    endtask

    task automatic put(logic [14:0] d, logic [3:0] c, logic mode);
        stb = 1; dat = d; ch = c; grp = 3'd5; xm = 2'd2; src = 1; cmp = 1; cm = mode;
        tick();
    endtask

    initial begin
        wm = 0; sen = 1; idle(); model_reset();
        repeat (2) @(negedge clk);
        #1;
        chk("R2", rdata, 32'd0);
        adr = 1; #1; chk("R2", rdata, 32'd0); adr = 0;
        chk("R2", {30'd0, res_valid, srq}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        // R4: overwrite replaces
        put(15'h1234, 4'd3, 0);
        put(15'h0abc, 4'd9, 0);
        #1; chk("R4", {17'd0, rdata[14:0]}, 32'h0abc);
        // R10: consuming read
        rd = 1; tick();
        chk("R10", {31'd0, res_valid}, 32'd0);
        // R5/R8: hold mode drops
        wm = 1;
        put(15'h0111, 4'd1, 0);
        put(15'h0222, 4'd2, 0);
        #1; chk("R5", {17'd0, rdata[14:0]}, 32'h0111);
        adr = 1; #1; chk("R8", {31'd0, rdata[1]}, 32'd1);
        wr = 1; adr = 1; wd = 32'h0002_0000; tick();
        adr = 1; #1; chk("R8", {31'd0, rdata[1]}, 32'd0); adr = 0;
        // R3: software clear beats store
        wm = 0;
        stb = 1; dat = 15'h0333; wr = 1; wd = 32'h8000_0000; tick();
        chk("R3", {31'd0, res_valid}, 32'd0);
        adr = 1; #1; chk("R3", {31'd0, rdata[2]}, 32'd0); adr = 0;
        // R9: compare mode keeps result
        stb = 1; cm = 1; dat = 15'h7fff; cmp = 1; ch = 4'd7; tick();
        #1; chk("R9", {17'd0, rdata[14:0]}, 32'h0333);
        chk("R9", {30'd0, rdata[31], rdata[29]}, 32'd3);
        // R11: other write bits ignored
        wr = 1; wd = 32'h7fff_ffff; tick();
        #1; chk("R11", rdata, w0());
        wr = 1; adr = 1; wd = 32'hfffc_ffff; tick();
        adr = 1; #1; chk("R11", rdata, 32'd5); adr = 0;
        // R6: event clear with store wins, then plain clear
        stb = 1; dat = 15'h0044; wr = 1; adr = 1; wd = 32'h0001_0000; tick();
        adr = 1; #1; chk("R6", {31'd0, rdata[0]}, 32'd1);
        wr = 1; adr = 1; wd = 32'h0001_0000; tick();
        adr = 1; #1; chk("R6", {31'd0, rdata[0]}, 32'd0); adr = 0;
        // sweep over all configurations with random traffic
        for (int cfg = 0; cfg < 4; cfg++) begin
            wm = cfg[0]; sen = cfg[1];
            for (int n = 0; n < 2000; n++) begin
                int op;
                op = $urandom % 4;
                stb = ($urandom % 3) == 0; cm = ($urandom % 4) == 0;
                dat = 15'($urandom); grp = 3'($urandom); ch = 4'($urandom);
                xm = 2'($urandom); src = 1'($urandom); cmp = 1'($urandom);
                adr = 1'($urandom);
                rd = (op == 1); wr = (op == 2); wd = $urandom;
                tick();
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule